// File: doc/BRIEF.md
# Two-Minima and Index Finder

This block sits inside a min-sum check-node unit. It receives K unsigned W-bit magnitudes at once. It reports three results: the smallest value, the second smallest value, and the position of the smallest value. The second smallest value is the smallest of what remains once a single copy of the smallest has been taken out.

The search is a recursive pairwise tree. Each tree node runs one compare-and-swap on the minima of its two halves. That one comparison fixes the node's minimum and one bit of its index. It also decides which half's list of runner-up candidates the node keeps. The node then adds the losing minimum to that list. A node that covers 2^m leaves therefore passes up exactly m candidates. A short reduction tree at the top picks the second minimum from those candidates. When K is not a power of two, the inputs are padded up to the next power of two with all-ones values, and those padded leaves can never win. By default an output register stage is present, with a valid flag delayed by one clock. With the register stage turned off, the block is purely combinational.

Top module: `two_min_finder`

## Requirements
- R1: `out_min1` equals the smallest of the K input values, where input i occupies bits `in_data[i*W +: W]`.
- R2: `out_idx` is the lowest position i whose value equals `out_min1`. On equal values the lower index wins.
- R3: `out_min2` is the smallest value left after one copy of `out_min1` is removed. When the minimum value appears at two or more positions, `out_min2` equals `out_min1`.
- R4: When all K inputs are equal, both minima equal that value and `out_idx` is 0.
- R5: When K is not a power of two, only the K real inputs affect the results. The padding leaves hold the all-ones value and are never reported.
- R6: With `REG_OUT=1`, the results for a vector sampled at a rising edge where `in_valid` is 1 appear after that edge. `out_valid` is `in_valid` delayed by one clock. All outputs hold their values after an edge where `in_valid` is 0.
- R7: With `REG_OUT=1`, a synchronous active-high `rst` clears `out_valid`, `out_min1`, `out_min2` and `out_idx` to zero.
- R8: With `REG_OUT=0`, the outputs follow the inputs combinationally and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input vector is valid |
| in_data | input | K*W | K packed unsigned magnitudes; value i occupies bits [i*W +: W] |
| out_valid | output | 1 | The results are valid |
| out_min1 | output | W | Smallest input value |
| out_min2 | output | W | Second smallest input value |
| out_idx | output | clog2(K) | Position of the smallest value |

## Verification
A combinational instance with five 3-bit inputs is swept through every one of its 32768 input vectors. This sweep covers every tie pattern and shows that the padding leaves of a non-power-of-two tree never reach the outputs. The registered eight-input instance gets four kinds of vectors, each exposing a different class of fault:
- Vectors where every input is equal expose tie handling.
- A single small value walked through every position catches an index bit taken from the wrong tree level.
- Duplicated minima placed at every pair of positions separate the lowest-index rule from a wrong choice of runner-up candidates.
- Random vectors, drawn over the full value range and over a narrow value range, mix everything else.

The sequences where `in_valid` is held low, and the reset at the start of the run, show the hold and clear behaviour of the register stage.

// File: rtl/two_min_pkg.sv
package two_min_pkg;
  // Number of tree levels needed to cover k leaves (at least one level).
  function automatic int unsigned tm_levels(input int unsigned k);
    int unsigned l;
    l = 1;
    while ((1 << l) < k) l++;
    return l;
  endfunction
endpackage

// File: rtl/tmf_cas.sv
module tmf_cas #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         take_b
);
  // Ties keep the left (a) operand as the smaller one.
  always_comb begin
    take_b = (b < a);
    lo     = take_b ? b : a;
    hi     = take_b ? a : b;
  end
endmodule

// File: rtl/tmf_node.sv
module tmf_node #(
  parameter int W = 8,
  parameter int M = 3
) (
  input  logic [(W << M)-1:0] vals,
  output logic [W-1:0]        node_min,
  output logic [M-1:0]        node_idx,
  output logic [M*W-1:0]      node_cand
);
  localparam int HALF = (1 << (M - 1)) * W;

  generate
    if (M == 1) begin : g_leaf
      logic [W-1:0] lo, hi;
      logic         sel;
      tmf_cas #(.W(W)) u_cas (
        .a(vals[W-1:0]), .b(vals[2*W-1:W]), .lo(lo), .hi(hi), .take_b(sel)
      );
      assign node_min  = lo;
      assign node_idx  = sel;
      assign node_cand = hi;
    end else begin : g_inner
      logic [W-1:0]         l_min, r_min, lo, hi;
      logic [M-2:0]         l_idx, r_idx;
      logic [(M-1)*W-1:0]   l_cand, r_cand;
      logic                 sel;

      tmf_node #(.W(W), .M(M-1)) u_left (
        .vals(vals[HALF-1:0]), .node_min(l_min), .node_idx(l_idx), .node_cand(l_cand)
      );
      tmf_node #(.W(W), .M(M-1)) u_right (
        .vals(vals[2*HALF-1:HALF]), .node_min(r_min), .node_idx(r_idx), .node_cand(r_cand)
      );
      tmf_cas #(.W(W)) u_cas (
        .a(l_min), .b(r_min), .lo(lo), .hi(hi), .take_b(sel)
      );

      // Only the winning half's candidates can hold the runner-up; the losing
      // half contributes just its own minimum.
      assign node_min  = lo;
      assign node_idx  = {sel, (sel ? r_idx : l_idx)};
      assign node_cand = {hi, (sel ? r_cand : l_cand)};
    end
  endgenerate
endmodule

// File: rtl/tmf_min_tree.sv
module tmf_min_tree #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic [N*W-1:0] cands,
  output logic [W-1:0]   best
);
  generate
    if (N == 1) begin : g_one
      assign best = cands;
    end else begin : g_split
      localparam int NL = N / 2;
      localparam int NR = N - NL;
      logic [W-1:0] l_best, r_best;
      tmf_min_tree #(.W(W), .N(NL)) u_l (.cands(cands[NL*W-1:0]), .best(l_best));
      tmf_min_tree #(.W(W), .N(NR)) u_r (.cands(cands[N*W-1:NL*W]), .best(r_best));
      assign best = (r_best < l_best) ? r_best : l_best;
    end
  endgenerate
endmodule

// File: rtl/two_min_finder.sv
module two_min_finder
  import two_min_pkg::*;
#(
  parameter int K       = 8,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int M      = tm_levels(K),
  localparam int KP     = 1 << M
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [K*W-1:0] in_data,
  output logic           out_valid,
  output logic [W-1:0]   out_min1,
  output logic [W-1:0]   out_min2,
  output logic [M-1:0]   out_idx
);
  logic [KP*W-1:0] leaves;
  logic [W-1:0]    t_min1, t_min2;
  logic [M-1:0]    t_idx;
  logic [M*W-1:0]  t_cand;

  generate
    if (KP > K) begin : g_pad
      assign leaves = {{((KP - K) * W){1'b1}}, in_data};
    end else begin : g_nopad
      assign leaves = in_data;
    end
  endgenerate

  tmf_node #(.W(W), .M(M)) u_root (
    .vals(leaves), .node_min(t_min1), .node_idx(t_idx), .node_cand(t_cand)
  );

  tmf_min_tree #(.W(W), .N(M)) u_second (
    .cands(t_cand), .best(t_min2)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_min1  <= '0;
          out_min2  <= '0;
          out_idx   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_min1 <= t_min1;
            out_min2 <= t_min2;
            out_idx  <= t_idx;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_min1  = t_min1;
      assign out_min2  = t_min2;
      assign out_idx   = t_idx;
    end
  endgenerate
endmodule

// File: rtl/two_min_finder_chk.sv
module two_min_finder_chk #(
  parameter int K       = 8,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int M       = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [K*W-1:0] in_data,
  input logic           out_valid,
  input logic [W-1:0]   out_min1,
  input logic [W-1:0]   out_min2,
  input logic [M-1:0]   out_idx
);
  logic [K*W-1:0] src;

  generate
    if (REG_OUT) begin : g_cap
      logic [K*W-1:0] cap_q;
      always_ff @(posedge clk) if (in_valid) cap_q <= in_data;
      assign src = cap_q;
    end else begin : g_dir
      assign src = in_data;
    end
  endgenerate

  int  below1, lt2, le2;
  logic idx_ok;

  always_comb begin
    below1 = 0;
    lt2    = 0;
    le2    = 0;
    idx_ok = (int'(out_idx) < K);
    for (int j = 0; j < K; j++) begin
      if (src[j*W +: W] < out_min1) below1++;
      if (src[j*W +: W] < out_min2) lt2++;
      if (src[j*W +: W] <= out_min2) le2++;
      if (j < int'(out_idx) && src[j*W +: W] == out_min1) idx_ok = 1'b0;
      if (j == int'(out_idx) && src[j*W +: W] != out_min1) idx_ok = 1'b0;
    end
  end

  // R1
  min1_floor_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (below1 == 0));

  // R2
  idx_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> idx_ok);

  // R3
  min2_rank_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lt2 <= 1 && le2 >= 2));

  generate
    if (REG_OUT) begin : g_seq
      // R6
      valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      // R6
      hold_min_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_min1) && $stable(out_min2) && $stable(out_idx)));
      // R7
      reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_min1 == '0 && out_min2 == '0 && out_idx == '0));
    end
  endgenerate
endmodule

bind two_min_finder two_min_finder_chk #(.K(K), .W(W), .REG_OUT(REG_OUT), .M(M)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_min1(out_min1), .out_min2(out_min2), .out_idx(out_idx)
);

// File: tb/two_min_finder_bench.sv
module two_min_finder_bench;
  localparam int KA = 8, WA = 8;
  localparam int KB = 5, WB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic            a_vin = 1'b0;
  logic [KA*WA-1:0] a_data = '0;
  logic            a_vout;
  logic [WA-1:0]   a_min1, a_min2;
  logic [2:0]      a_idx;

  logic [KB*WB-1:0] b_data = '0;
  logic            b_vout;
  logic [WB-1:0]   b_min1, b_min2;
  logic [2:0]      b_idx;

  two_min_finder #(.K(KA), .W(WA), .REG_OUT(1'b1)) u_two_min_finder (
    .clk(clk), .rst(rst), .in_valid(a_vin), .in_data(a_data),
    .out_valid(a_vout), .out_min1(a_min1), .out_min2(a_min2), .out_idx(a_idx)
  );

  two_min_finder #(.K(KB), .W(WB), .REG_OUT(1'b0)) u_two_min_finder_odd (
    .clk(clk), .rst(rst), .in_valid(1'b1), .in_data(b_data),
    .out_valid(b_vout), .out_min1(b_min1), .out_min2(b_min2), .out_idx(b_idx)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: scan for the first strict minimum, then the minimum of the rest.
  task automatic ref_model(input int v[8], input int n, output int m1, output int m2, output int ix);
    m1 = v[0]; ix = 0;
    for (int i = 1; i < n; i++) if (v[i] < m1) begin m1 = v[i]; ix = i; end
    m2 = 1 << 30;
    for (int i = 0; i < n; i++) if (i != ix && v[i] < m2) m2 = v[i];
  endtask

  task automatic run_a(input int v[8], input string req);
    int m1, m2, ix;
    ref_model(v, KA, m1, m2, ix);
    @(negedge clk);
    for (int i = 0; i < KA; i++) a_data[i*WA +: WA] = v[i][WA-1:0];
    a_vin = 1'b1;
    @(negedge clk);
    chk(a_vout == 1'b1, "R6", "out_valid", int'(a_vout), 1);
    chk(int'(a_min1) == m1, "R1", req, int'(a_min1), m1);
    chk(int'(a_idx) == ix, "R2", req, int'(a_idx), ix);
    chk(int'(a_min2) == m2, "R3", req, int'(a_min2), m2);
    a_vin = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v[8];
    int m1, m2, ix, hold1, hold2, holdi;
    // R7: synchronous reset clears the registered outputs
    repeat (3) @(negedge clk);
    chk(a_vout == 1'b0, "R7", "reset out_valid", int'(a_vout), 0);
    chk(a_min1 == '0 && a_min2 == '0, "R7", "reset minima", int'(a_min1) + int'(a_min2), 0);
    chk(a_idx == '0, "R7", "reset idx", int'(a_idx), 0);
    rst = 1'b0;

    // R4: all inputs equal
    foreach (v[i]) v[i] = 0;
    run_a(v, "R4 all zero");
    foreach (v[i]) v[i] = 255;
    run_a(v, "R4 all ones");
    foreach (v[i]) v[i] = 77;
    run_a(v, "R4 all 77");
    chk(a_idx == 3'd0 && a_min1 == 8'd77 && a_min2 == 8'd77, "R4", "equal set", int'(a_idx), 0);

    // R2: a single minimum at each position
    for (int p = 0; p < KA; p++) begin
      foreach (v[i]) v[i] = 200 - i;
      v[p] = 10 + p;
      run_a(v, "R2 walk");
    end

    // R3: duplicated minimum at every pair of positions
    for (int p = 0; p < KA; p++)
      for (int q = p + 1; q < KA; q++) begin
        foreach (v[i]) v[i] = 100 + 3 * i;
        v[p] = 42; v[q] = 42;
        run_a(v, "R3 dup");
      end

    // R1: random vectors over the full range and over a narrow range
    for (int t = 0; t < 1200; t++) begin
      foreach (v[i]) v[i] = (t % 2 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 3));
      run_a(v, "R1 random");
    end

    // R6: in_valid low holds every output and drops out_valid
    hold1 = int'(a_min1); hold2 = int'(a_min2); holdi = int'(a_idx);
    @(negedge clk);
    a_data = '0;
    a_vin = 1'b0;
    @(negedge clk);
    chk(a_vout == 1'b0, "R6", "hold out_valid", int'(a_vout), 0);
    chk(int'(a_min1) == hold1 && int'(a_min2) == hold2 && int'(a_idx) == holdi,
        "R6", "hold values", int'(a_min1), hold1);

    // R5, R8: exhaustive sweep of the combinational five-input instance
    for (int c = 0; c < (1 << (KB * WB)); c++) begin
      bit ok;
      b_data = c[KB*WB-1:0];
      foreach (v[i]) v[i] = 0;
      for (int i = 0; i < KB; i++) v[i] = (c >> (i * WB)) & 7;
      ref_model(v, KB, m1, m2, ix);
      #1;
      ok = (int'(b_min1) == m1) && (int'(b_min2) == m2) && (int'(b_idx) == ix) && b_vout;
      chk(ok, "R5", $sformatf("R8 sweep vector %0d min1/min2/idx=%0d/%0d/%0d", c, b_min1, b_min2, b_idx),
          m1 * 100 + m2 * 10 + ix, m1 * 100 + m2 * 10 + ix + (ok ? 0 : 1));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule